// File: doc/BRIEF.md
# Power Converter Fault Supervisor

This block watches the protection flags of a switching regulator and decides how the controller reacts to each fault. Four comparator outputs (output over-voltage, output under-voltage, a die-hot flag and a die-cooled flag) come in as asynchronous levels, together with an external over-current latch flag and an external enable. The block drives the chip enable, the high-side enable, a low-side force-high request, an internal power-on-reset pulse and a soft-start request. It also returns a 3-bit fault status.

Over-voltage acts as a soft crowbar. It turns the low-side switch on for as long as the flag stays high and never shuts the chip down. Under-voltage and over-current stop the converter and hold it stopped until the enable is dropped. A thermal fault holds the converter off until the die has cooled. The block then restarts it through a power-on-reset pulse and a full soft-start handshake. Every enable from the off state goes through the same reset and soft-start sequence.

Top module: `pwr_fault_sup`

## Requirements
- R1: Every asynchronous input (enable, over-voltage, under-voltage, hot, cooled, over-current) passes through a SYNC_STAGES-flop synchronizer, default 2. `ls_force_o` follows the over-voltage input 3 clocks later in every state, including while the chip is disabled or shut down.
- R2: Over-voltage alone never changes the sequencing state. While the synchronized flag is high, `hs_en_o` is low and `chip_en_o` is unchanged. When the flag drops, the force releases and `hs_en_o` returns.
- R3: Under-voltage seen in the running state drops `chip_en_o` and `hs_en_o` on the next clock and reports status 2. The shutdown stays latched after the flag clears, as long as the enable stays high.
- R4: The hot flag shuts the converter down from the off, reset, soft-start or running state and reports status 3. The shutdown holds until the cooled flag is high and the hot flag is low.
- R5: Leaving a thermal shutdown, and every enable from off, raises `por_o` for exactly POR_CYCLES clocks (default 4). Then `ss_req_o` stays high until `ss_done_i` is seen, and only after that is the converter running.
- R6: The over-current input seen during soft-start or running shuts the converter down and latches it with status 4.
- R7: A low synchronized enable forces the off state from any state. It clears the latched under-voltage and over-current shutdowns and gives status 0.
- R8: `chip_en_o` is high only in soft-start and running. `hs_en_o` is never high while `chip_en_o` is low.
- R9: The status encoding is 0 none, 1 over-voltage, 2 under-voltage, 3 over-temperature, 4 over-current. A shutdown code takes precedence over 1.
- R10: Under-voltage is ignored outside the running state. Over-current is ignored in the off and reset states.
- R11: The synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | External enable, asynchronous |
| ov_i | input | 1 | Output over-voltage flag |
| uv_i | input | 1 | Output under-voltage flag |
| ot_hot_i | input | 1 | Die above the upper temperature threshold |
| ot_cool_i | input | 1 | Die below the lower temperature threshold |
| oc_i | input | 1 | External over-current latch flag |
| ss_done_i | input | 1 | Soft-start ramp finished, synchronous |
| chip_en_o | output | 1 | Converter enabled |
| hs_en_o | output | 1 | High-side driver enable |
| ls_force_o | output | 1 | Force the low-side driver on |
| por_o | output | 1 | Internal power-on-reset pulse |
| ss_req_o | output | 1 | Soft-start request |
| fault_code_o | output | 3 | Active fault status |

## Verification
The bench builds the block with its defaults: SYNC_STAGES of 2 and POR_CYCLES of 4. With these values a short run reaches every state. The bench also times the reset pulse on a thermal restart against the exact cycle count. A reference model delays the raw inputs through a history queue that is as deep as the synchronizer, so the model is compared exactly, cycle for cycle. Each kind of latched shutdown is tested with its flag removed and with other faults added, to show that it stays latched.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    SQ_OFF, SQ_POR, SQ_SOFT, SQ_RUN, SQ_UV, SQ_OC, SQ_OT
  } seq_t;

  localparam logic [2:0] CODE_NONE = 3'd0;
  localparam logic [2:0] CODE_OV   = 3'd1;
  localparam logic [2:0] CODE_UV   = 3'd2;
  localparam logic [2:0] CODE_OT   = 3'd3;
  localparam logic [2:0] CODE_OC   = 3'd4;

  // bit positions in the synchronized flag vector
  localparam int IDX_EN  = 0;
  localparam int IDX_OV  = 1;
  localparam int IDX_UV  = 2;
  localparam int IDX_HOT = 3;
  localparam int IDX_CL  = 4;
  localparam int IDX_OC  = 5;
  localparam int FLAG_N  = 6;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
      end else begin
        chain[0] <= d[b];
        for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
  import pfs_pkg::*;
#(
  parameter int POR_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic s_en,
  input  logic s_uv,
  input  logic s_hot,
  input  logic s_cool,
  input  logic s_oc,
  input  logic ss_done,
  output seq_t st_nxt
);
  localparam int CNT_W = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_CYCLES - 1);

  seq_t             st;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    if (!s_en) begin
      st_nxt = SQ_OFF;
    end else begin
      case (st)
        SQ_OT: begin
          if (s_cool && !s_hot) begin
            st_nxt  = SQ_POR;
            cnt_nxt = POR_LAST;
          end
        end
        SQ_UV, SQ_OC: st_nxt = st;
        default: begin
          if (s_hot) begin
            st_nxt = SQ_OT;
          end else if (s_uv && st == SQ_RUN) begin
            st_nxt = SQ_UV;
          end else if (s_oc && (st == SQ_SOFT || st == SQ_RUN)) begin
            st_nxt = SQ_OC;
          end else begin
            case (st)
              SQ_OFF: begin
                st_nxt  = SQ_POR;
                cnt_nxt = POR_LAST;
              end
              SQ_POR: begin
                if (cnt == '0) st_nxt = SQ_SOFT;
                else cnt_nxt = cnt - 1'b1;
              end
              SQ_SOFT: if (ss_done) st_nxt = SQ_RUN;
              default: st_nxt = st;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SQ_OFF;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/pfs_out.sv
module pfs_out
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_t       st_nxt,
  input  logic       s_ov,
  output logic       chip_en,
  output logic       hs_en,
  output logic       ls_force,
  output logic       por,
  output logic       ss_req,
  output logic [2:0] code
);
  logic       chip_d;
  logic [2:0] code_d;

  always_comb begin
    chip_d = (st_nxt == SQ_SOFT) || (st_nxt == SQ_RUN);
    case (st_nxt)
      SQ_OT:   code_d = CODE_OT;
      SQ_UV:   code_d = CODE_UV;
      SQ_OC:   code_d = CODE_OC;
      default: code_d = s_ov ? CODE_OV : CODE_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_en  <= 1'b0;
      hs_en    <= 1'b0;
      ls_force <= 1'b0;
      por      <= 1'b0;
      ss_req   <= 1'b0;
      code     <= CODE_NONE;
    end else begin
      chip_en  <= chip_d;
      hs_en    <= chip_d && !s_ov;
      ls_force <= s_ov;
      por      <= (st_nxt == SQ_POR);
      ss_req   <= (st_nxt == SQ_SOFT);
      code     <= code_d;
    end
  end
endmodule

// File: rtl/pwr_fault_sup.sv
module pwr_fault_sup
  import pfs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POR_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       ov_i,
  input  logic       uv_i,
  input  logic       ot_hot_i,
  input  logic       ot_cool_i,
  input  logic       oc_i,
  input  logic       ss_done_i,
  output logic       chip_en_o,
  output logic       hs_en_o,
  output logic       ls_force_o,
  output logic       por_o,
  output logic       ss_req_o,
  output logic [2:0] fault_code_o
);
  logic [FLAG_N-1:0] raw_vec, s_vec;
  logic s_en, s_ov;
  seq_t st_nxt;

  always_comb begin
    raw_vec          = '0;
    raw_vec[IDX_EN]  = en_i;
    raw_vec[IDX_OV]  = ov_i;
    raw_vec[IDX_UV]  = uv_i;
    raw_vec[IDX_HOT] = ot_hot_i;
    raw_vec[IDX_CL]  = ot_cool_i;
    raw_vec[IDX_OC]  = oc_i;
  end

  pfs_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(raw_vec), .q(s_vec)
  );

  assign s_en = s_vec[IDX_EN];
  assign s_ov = s_vec[IDX_OV];

  pfs_seq #(.POR_CYCLES(POR_CYCLES)) i_seq (
    .clk(clk), .rst(rst),
    .s_en(s_en), .s_uv(s_vec[IDX_UV]), .s_hot(s_vec[IDX_HOT]),
    .s_cool(s_vec[IDX_CL]), .s_oc(s_vec[IDX_OC]),
    .ss_done(ss_done_i), .st_nxt(st_nxt)
  );

  pfs_out i_out (
    .clk(clk), .rst(rst), .st_nxt(st_nxt), .s_ov(s_ov),
    .chip_en(chip_en_o), .hs_en(hs_en_o), .ls_force(ls_force_o),
    .por(por_o), .ss_req(ss_req_o), .code(fault_code_o)
  );
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk (
  input logic       clk,
  input logic       rst,
  input logic       s_en,
  input logic       s_ov,
  input logic       chip_en_o,
  input logic       hs_en_o,
  input logic       ls_force_o,
  input logic       por_o,
  input logic       ss_req_o,
  input logic [2:0] fault_code_o
);
  p_ls_track_r1: assert property (@(posedge clk) disable iff (rst || $past(rst))
    1'b1 |-> (ls_force_o == $past(s_ov)));

  p_hs_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !chip_en_o |-> !hs_en_o);

  p_uv_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (fault_code_o == 3'd2) ##1 s_en |=> (fault_code_o == 3'd2));

  p_oc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (fault_code_o == 3'd4) ##1 s_en |=> (fault_code_o == 3'd4));

  p_ot_off_r4: assert property (@(posedge clk) disable iff (rst)
    (fault_code_o == 3'd3) |-> (!chip_en_o && !ss_req_o));

  p_por_excl_r5: assert property (@(posedge clk) disable iff (rst)
    por_o |-> (!chip_en_o && !ss_req_o));
endmodule

bind pwr_fault_sup pfs_chk i_chk (
  .clk(clk), .rst(rst), .s_en(s_en), .s_ov(s_ov),
  .chip_en_o(chip_en_o), .hs_en_o(hs_en_o), .ls_force_o(ls_force_o),
  .por_o(por_o), .ss_req_o(ss_req_o), .fault_code_o(fault_code_o)
);

// File: tb/test_pwr_fault_sup.sv
module test_pwr_fault_sup;
  localparam int SYNC = 2;
  localparam int PORC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, ov = 0, uv = 0, hot = 0, cool = 0, oc = 0, ssd = 0;
  logic chip, hs, ls, por, ssr;
  logic [2:0] code;

  always #5 clk = ~clk;

  pwr_fault_sup #(.SYNC_STAGES(SYNC), .POR_CYCLES(PORC)) i_pwr_fault_sup (
    .clk(clk), .rst(rst), .en_i(en), .ov_i(ov), .uv_i(uv),
    .ot_hot_i(hot), .ot_cool_i(cool), .oc_i(oc), .ss_done_i(ssd),
    .chip_en_o(chip), .hs_en_o(hs), .ls_force_o(ls), .por_o(por),
    .ss_req_o(ssr), .fault_code_o(code)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R11";
  bit done = 0;

  // reference model: 0 off,1 reset,2 soft,3 run,4 uv,5 oc,6 ot
  logic [5:0] hist[$];
  int ms = 0, mc = 0;
  logic e_chip = 0, e_hs = 0, e_ls = 0, e_por = 0, e_ss = 0;
  logic [2:0] e_code = 0;

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      ms = 0; mc = 0;
      e_chip = 0; e_hs = 0; e_ls = 0; e_por = 0; e_ss = 0; e_code = 0;
    end else begin
      logic [5:0] sv;
      hist.push_front({oc, cool, hot, uv, ov, en});
      sv = (hist.size() > SYNC) ? hist[SYNC] : 6'd0;
      if (hist.size() > SYNC + 1) void'(hist.pop_back());
      if (!sv[0]) ms = 0;
      else if (ms == 6) begin
        if (sv[4] && !sv[3]) begin ms = 1; mc = PORC; end
      end
      else if (ms == 4 || ms == 5) ms = ms;
      else if (sv[3]) ms = 6;
      else if (sv[2] && ms == 3) ms = 4;
      else if (sv[5] && (ms == 2 || ms == 3)) ms = 5;
      else if (ms == 0) begin ms = 1; mc = PORC; end
      else if (ms == 1) begin mc--; if (mc == 0) ms = 2; end
      else if (ms == 2 && ssd) ms = 3;
      e_chip = (ms == 2 || ms == 3);
      e_hs   = e_chip && !sv[1];
      e_ls   = sv[1];
      e_por  = (ms == 1);
      e_ss   = (ms == 2);
      e_code = (ms == 6) ? 3'd3 : (ms == 4) ? 3'd2 : (ms == 5) ? 3'd4 :
               sv[1] ? 3'd1 : 3'd0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if ({chip, hs, ls, por, ssr, code} !== {e_chip, e_hs, e_ls, e_por, e_ss, e_code}) begin
        n_bad++;
        $display("FAIL %s model: got chip%b hs%b ls%b por%b ss%b code%0d exp chip%b hs%b ls%b por%b ss%b code%0d",
                 cur_req, chip, hs, ls, por, ssr, code, e_chip, e_hs, e_ls, e_por, e_ss, e_code);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_run();
    en = 1; ssd = 0;
    step(SYNC + PORC + 4);
    ssd = 1; step(2); ssd = 0; step(1);
  endtask

  initial begin
    step(3);
    check({chip, hs, ls, por, ssr, code} == 8'd0, "R11 reset outputs", {chip, hs, ls, por, ssr, code}, 0);
    rst = 0; step(1);

    // start-up, under-voltage during soft-start is ignored
    cur_req = "R10"; en = 1;
    step(SYNC + PORC + 2);
    uv = 1; step(5);
    check(ssr && code == 3'd0, "R10 uv ignored in soft-start", code, 0);
    uv = 0; step(SYNC + 1);
    cur_req = "R5"; ssd = 1; step(2); ssd = 0; step(1);
    check(chip && hs, "R8 running enables", {chip, hs}, 3);

    // over-voltage soft crowbar
    cur_req = "R1"; ov = 1; step(SYNC + 2);
    check(ls && !hs && chip, "R1 force low side", {ls, hs, chip}, 5);
    check(code == 3'd1, "R9 ov code", code, 1);
    cur_req = "R2"; ov = 0; step(SYNC + 2);
    check(!ls && hs && chip, "R2 force released", {ls, hs, chip}, 3);

    // under-voltage latch
    cur_req = "R3"; uv = 1; step(SYNC + 2);
    check(!chip && !hs && code == 3'd2, "R3 uv shutdown", code, 2);
    uv = 0; ov = 1; step(SYNC + 3);
    check(code == 3'd2 && ls && !hs, "R3 uv latched, R9 priority over ov", code, 2);
    ov = 0; step(SYNC + 1);

    // enable toggle clears
    cur_req = "R7"; en = 0; step(SYNC + 2);
    check(code == 3'd0 && !chip && !por, "R7 cleared by enable", code, 0);
    start_run();
    check(chip && code == 3'd0, "R7 restart reaches run", code, 0);

    // over-current latch
    cur_req = "R6"; oc = 1; step(SYNC + 2); oc = 0; step(SYNC + 3);
    check(code == 3'd4 && !chip, "R6 oc latched", code, 4);
    en = 0; step(SYNC + 2);

    // over-current during reset pulse is ignored
    cur_req = "R10"; en = 1; step(SYNC + 1);
    oc = 1; step(2); oc = 0;
    step(PORC + 2);
    check(ssr && code == 3'd0, "R10 oc ignored during reset", code, 0);
    ssd = 1; step(2); ssd = 0; step(1);

    // thermal shutdown with hysteresis
    cur_req = "R4"; hot = 1; uv = 1; step(SYNC + 2);
    check(code == 3'd3 && !chip, "R4 ot shutdown, R9 over uv", code, 3);
    hot = 0; uv = 0; step(SYNC + 4);
    check(code == 3'd3, "R4 held until cool", code, 3);
    cur_req = "R5"; cool = 1;
    begin
      int wait_c = 0, width = 0;
      while (!por && wait_c < 20) begin step(1); wait_c++; end
      while (por && width < 20) begin step(1); width++; end
      check(width == PORC, "R5 reset pulse width", width, PORC);
    end
    check(ssr && chip && !hs == 0, "R5 soft-start after reset", ssr, 1);
    step(4);
    check(ssr && code == 3'd0, "R5 waits for done", ssr, 1);
    cool = 0; ssd = 1; step(2); ssd = 0; step(1);
    check(chip && hs && !ssr, "R5 running after done", {chip, hs, ssr}, 6);

    // over-voltage while disabled still forces low side
    cur_req = "R1"; en = 0; step(SYNC + 2); ov = 1; step(SYNC + 2);
    check(ls && !chip && !hs, "R1 force while disabled", {ls, chip, hs}, 4);
    ov = 0; step(SYNC + 2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule